// File: doc/BRIEF.md
# Scanline interrupt counter

This block raises a CPU interrupt after a programmed number of rendered scanlines. It sits in a cartridge mapper. The CPU programs it through four write-only ports decoded in the upper quarter of its address space. The scanline clock is taken from the video chip's pattern-table address line A12. That line rises once per rendered line, but it can also toggle briefly within a line. The block therefore counts a rising edge only after the line has been low for a minimum number of CPU cycles.

The block keeps three items of state:
- a reload latch, which holds the reload value;
- an 8-bit down-counter;
- a reload-request flag and an enable flag.

On each qualified scanline clock, the counter is refilled from the latch if it is zero or if a refill has been requested. Otherwise it steps down by one. When the step leaves the counter at zero and interrupts are enabled, the active-low interrupt output is asserted. The output stays asserted until software acknowledges it. The acknowledge also disables further interrupts, but counting goes on while interrupts are disabled.

Top module: `scanline_irq`

## Requirements
- R1: While rst_n is low, irq_n is driven high, and the counter, latch, refill flag, enable flag and pending interrupt are all cleared. After reset, enabling and then sending one scanline with no other programming therefore asserts irq_n, because the latch holds 0.
- R2: A write is decoded only when cpu_addr_hi[15:14] = 2'b11. The function is chosen by cpu_addr_hi[13] and cpu_addr_lsb:
  - 0,0: latch write;
  - 0,1: refill request;
  - 1,0: acknowledge and disable;
  - 1,1: enable.

  All other address bits are ignored, so the ports mirror. Writes with any other value of cpu_addr_hi[15:14] have no effect.
- R3: A latch write stores cpu_data in the latch only and leaves the running counter untouched.
- R4: On each qualified scanline clock, the counter is loaded from the latch and the refill flag is cleared if the counter is zero or the refill flag is set. Otherwise the counter decrements by one.
- R5: When the counter is zero after a scanline step and interrupts are enabled, irq_n goes low on the clock edge that follows the qualifying edge.
- R6: Once low, irq_n stays low across further scanlines and unrelated writes until an acknowledge write.
- R7: An acknowledge write drives irq_n high on the next clock and disables interrupt generation. The counter keeps stepping and reloading while interrupts are disabled.
- R8: An enable write re-enables interrupt generation from the next scanline step onward.
- R9: a12 is sampled on every clk edge. A sample of 1 is a scanline clock only if the preceding LOW_MIN samples (default 3) were all 0. Shorter low pulses and a12 held high produce no step.
- R10: With the latch at 0, every scanline step leaves the counter at zero, so irq_n re-asserts on each scanline after an acknowledge and a re-enable.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | CPU cycle clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_wr | input | 1 | CPU write strobe, one cycle per write |
| cpu_addr_hi | input | 3 | CPU address bits 15 to 13 |
| cpu_addr_lsb | input | 1 | CPU address bit 0 |
| cpu_data | input | 8 | CPU write data |
| a12 | input | 1 | Raw pattern-table address line A12 |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
The hardest behaviour to observe from the ports is the hidden counter value. The three cases are: the counter going on while interrupts are disabled, a latch write that leaves the running count alone, and a refill request made in the middle of a count. None of them changes irq_n at the moment it happens. The stimulus programs a known count and then disables interrupts for a number of lines, or rewrites the latch, or requests a refill part way through. It then re-enables and counts the lines until irq_n falls. A model that froze the count while disabled, or that let a latch write reach the counter, would produce the interrupt on a different line. Short A12 pulses are inserted between full lines, and the interrupt line is expected to stay where it was.

// File: rtl/scanline_irq.sv
module scanline_irq #(
  parameter int CNT_W   = 8,
  parameter int LOW_MIN = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cpu_wr,
  input  logic [15:13]     cpu_addr_hi,
  input  logic             cpu_addr_lsb,
  input  logic [CNT_W-1:0] cpu_data,
  input  logic             a12,
  output logic             irq_n
);
  localparam int LW = $clog2(LOW_MIN + 1);

  logic [LW-1:0]    low_cnt;
  logic [CNT_W-1:0] latch_q, cnt_q, cnt_nx;
  logic             refill_q, en_q, pend_q;

  wire in_win    = cpu_wr & cpu_addr_hi[15] & cpu_addr_hi[14];
  wire wr_latch  = in_win & ~cpu_addr_hi[13] & ~cpu_addr_lsb;
  wire wr_refill = in_win & ~cpu_addr_hi[13] &  cpu_addr_lsb;
  wire wr_off    = in_win &  cpu_addr_hi[13] & ~cpu_addr_lsb;
  wire wr_on     = in_win &  cpu_addr_hi[13] &  cpu_addr_lsb;

  wire tick = a12 && (low_cnt >= LW'(LOW_MIN));

  always_ff @(posedge clk) begin
    if (!rst_n)                        low_cnt <= '0;
    else if (a12)                      low_cnt <= '0;
    else if (low_cnt != LW'(LOW_MIN))  low_cnt <= low_cnt + 1'b1;
  end

  assign cnt_nx = (cnt_q == '0 || refill_q) ? latch_q : cnt_q - 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      latch_q  <= '0;
      cnt_q    <= '0;
      refill_q <= 1'b0;
      en_q     <= 1'b0;
      pend_q   <= 1'b0;
    end else begin
      if (wr_latch) latch_q <= cpu_data;
      if (tick)     cnt_q   <= cnt_nx;
      if (wr_refill)   refill_q <= 1'b1;
      else if (tick)   refill_q <= 1'b0;
      if (wr_off)      en_q <= 1'b0;
      else if (wr_on)  en_q <= 1'b1;
      if (wr_off)                               pend_q <= 1'b0;
      else if (tick && cnt_nx == '0 && en_q)    pend_q <= 1'b1;
    end
  end

  assign irq_n = ~pend_q;

  // R6: held until acknowledged
  a_r6_irq_held: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_n && !wr_off) |=> !irq_n);

  // R7: acknowledge releases the line
  a_r7_ack_release: assert property (@(posedge clk) disable iff (!rst_n)
    wr_off |=> irq_n);

  // R7: no interrupt while disabled
  a_r7_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_n && !en_q) |=> irq_n);

  // R5: assertion only follows a scanline step
  a_r5_fall_on_step: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_n) |-> $past(tick));

  // R9: a step needs a low-to-high transition of a12
  a_r9_edge_only: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> !$past(a12));

  // R3: latch writes never move the counter on their own
  a_r3_latch_isolated: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_latch && !tick) |=> $stable(cnt_q));
endmodule

// File: tb/scanline_irq_test.sv
module scanline_irq_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_wr = 1'b0;
  logic [15:13] cpu_addr_hi = 3'b000;
  logic        cpu_addr_lsb = 1'b0;
  logic [7:0]  cpu_data = 8'h00;
  logic        a12 = 1'b0;
  logic        irq_n;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  typedef struct { logic exp; string tag; } item_t;
  item_t sb[$];
  event  ev;

  always #10 clk = ~clk;

  scanline_irq uut (
    .clk(clk), .rst_n(rst_n), .cpu_wr(cpu_wr), .cpu_addr_hi(cpu_addr_hi),
    .cpu_addr_lsb(cpu_addr_lsb), .cpu_data(cpu_data), .a12(a12), .irq_n(irq_n)
  );

  initial begin
    forever begin
      @(ev);
      while (sb.size() > 0) begin
        item_t it;
        it = sb.pop_front();
        checks++;
        if (irq_n !== it.exp) begin
          fails++;
          $display("FAIL %s: irq_n=%b expected %b", it.tag, irq_n, it.exp);
        end
      end
    end
  end

  task automatic expect_irq(input logic e, input string tag);
    sb.push_back('{e, tag});
    -> ev;
    #1;
  endtask

  task automatic wr(input logic [15:0] addr, input logic [7:0] d);
    @(negedge clk);
    cpu_addr_hi  = addr[15:13];
    cpu_addr_lsb = addr[0];
    cpu_data     = d;
    cpu_wr       = 1'b1;
    @(negedge clk);
    cpu_wr = 1'b0;
  endtask

  task automatic line(input logic e, input string tag);
    @(negedge clk);
    a12 = 1'b0;
    repeat (4) @(negedge clk);
    a12 = 1'b1;
    @(negedge clk);
    expect_irq(e, tag);
    repeat (3) @(negedge clk);
  endtask

  task automatic glitch(input string tag);
    @(negedge clk);
    a12 = 1'b0;
    repeat (2) @(negedge clk);
    a12 = 1'b1;
    repeat (2) @(negedge clk);
    expect_irq(1'b1, tag);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    expect_irq(1'b1, "R1 reset level");
    rst_n = 1'b1;
    @(negedge clk);
    expect_irq(1'b1, "R1 after reset release");
    wr(16'hE001, 8'h00);
    line(1'b0, "R1 latch cleared to zero");
    wr(16'hE000, 8'h00);
    expect_irq(1'b1, "R7 ack");

    wr(16'hC000, 8'd3);
    wr(16'hC001, 8'h00);
    wr(16'hE001, 8'h00);
    line(1'b1, "R4 refill to 3");
    line(1'b1, "R4 count 2");
    line(1'b1, "R4 count 1");
    line(1'b0, "R5 zero asserts next clock");
    line(1'b0, "R6 held over next line");
    wr(16'h6000, 8'h00);
    wr(16'hA000, 8'h00);
    expect_irq(1'b0, "R2 out-of-window writes ignored");
    wr(16'hE000, 8'h00);
    expect_irq(1'b1, "R7 ack releases");

    line(1'b1, "R7 disabled count 2");
    line(1'b1, "R7 disabled count 1");
    line(1'b1, "R7 disabled count 0 no irq");
    wr(16'hE001, 8'h00);
    line(1'b1, "R8 refill 3 after enable");
    line(1'b1, "R8 count 2");
    line(1'b1, "R8 count 1");
    line(1'b0, "R7 counting continued while disabled");

    wr(16'hE000, 8'h00);
    wr(16'hE001, 8'h00);
    wr(16'hC000, 8'd1);
    line(1'b1, "R3 latch write left counter at zero");
    line(1'b0, "R3 irq after new latch value");

    wr(16'hE000, 8'h00);
    wr(16'hE001, 8'h00);
    wr(16'hC000, 8'd5);
    line(1'b1, "R4 refill 5");
    line(1'b1, "R4 count 4");
    wr(16'hC001, 8'h00);
    line(1'b1, "R4 mid-count refill to 5");
    line(1'b1, "R4 count 4 after refill");
    line(1'b1, "R4 count 3");
    line(1'b1, "R4 count 2");
    line(1'b1, "R4 count 1");
    line(1'b0, "R4 zero after refill");

    wr(16'hE000, 8'h00);
    wr(16'hE001, 8'h00);
    wr(16'hC000, 8'd1);
    line(1'b1, "R9 refill 1");
    glitch("R9 short pulse a");
    glitch("R9 short pulse b");
    glitch("R9 short pulse c");
    line(1'b0, "R9 full line counts");

    wr(16'hE002, 8'h00);
    expect_irq(1'b1, "R2 mirrored ack");
    wr(16'hFFFF, 8'h00);
    line(1'b1, "R2 mirrored enable refill 1");
    wr(16'hC000, 8'd0);
    line(1'b0, "R10 count 1 to 0");
    wr(16'hE000, 8'h00);
    wr(16'hE001, 8'h00);
    line(1'b0, "R10 zero latch re-asserts");
    wr(16'hE000, 8'h00);
    expect_irq(1'b1, "R10 ack");
    wr(16'hE001, 8'h00);
    line(1'b0, "R10 re-asserts again");

    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    expect_irq(1'b1, "R1 mid-run reset");
    rst_n = 1'b1;
    wr(16'hC000, 8'd4);
    wr(16'hE001, 8'h00);
    line(1'b1, "R1 counter zero takes latch 4");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule